// File: doc/BRIEF.md
# Processor Status Flag Register

This block holds the six architectural condition and mode flags of a small 8-bit processor core: carry, zero, interrupt-disable, decimal, overflow and negative. The instruction decoder steers each flag with its own group of one-cycle load strobes. Each strobe names one source for that flag. The possible sources are a data bus bit, bit 5 of the instruction register, the ALU carry or overflow output, a detector that sees an all-zero data bus, or a constant.

Bit 5 of the instruction register carries the value for the set-flag and clear-flag instructions, so a single strobe per flag serves both. When the decoder asserts the read-out enable, the flags are packed into one byte and placed on the data bus. This is how the status word is pushed or transferred.

Top module: `status_flags`

## Requirements
- R1: While reset is held and on the first cycle after it, carry, zero, decimal, overflow and negative are 0 and interrupt-disable is 1.
- R2: A flag with none of its strobes active on a clock edge keeps its value across that edge.
- R3: Carry takes, in falling priority, data bus bit 0 (`ld_c_db`), instruction bit 5 (`ld_c_ir`) or the ALU carry-out (`ld_c_alu`) on the next edge.
- R4: Zero takes data bus bit 1 (`ld_z_db`) or, at lower priority, 1 when all data bus bits are 0 and 0 otherwise (`ld_z_zero`).
- R5: Interrupt-disable takes data bus bit 2 (`ld_i_db`) or, at lower priority, instruction bit 5 (`ld_i_ir`).
- R6: Decimal takes data bus bit 3 (`ld_d_db`) or, at lower priority, instruction bit 5 (`ld_d_ir`).
- R7: Overflow takes, in falling priority, data bus bit 6 (`ld_v_db`), the ALU overflow output (`ld_v_alu`), the constant 1 (`set_v`) or the constant 0 (`clr_v`).
- R8: Negative takes data bus bit 7 when `ld_n_db` is high.
- R9: While `drive_db` is high, `dbus_oe` is 1 and `dbus_out` is {N, V, 1, 0, D, I, Z, C} with C at bit 0. While it is low, `dbus_oe` is 0 and `dbus_out` is all zeros. Both follow the current flags and the enable with no cycle of delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dbus_in | input | 8 | Data bus value seen by the register |
| ir_bit5 | input | 1 | Instruction register bit 5 |
| alu_cout | input | 1 | ALU carry output |
| alu_vout | input | 1 | ALU overflow output |
| ld_c_db | input | 1 | Load carry from data bus bit 0 |
| ld_c_ir | input | 1 | Load carry from instruction bit 5 |
| ld_c_alu | input | 1 | Load carry from ALU carry output |
| ld_z_db | input | 1 | Load zero from data bus bit 1 |
| ld_z_zero | input | 1 | Load zero from the all-zero detector |
| ld_i_db | input | 1 | Load interrupt-disable from data bus bit 2 |
| ld_i_ir | input | 1 | Load interrupt-disable from instruction bit 5 |
| ld_d_db | input | 1 | Load decimal from data bus bit 3 |
| ld_d_ir | input | 1 | Load decimal from instruction bit 5 |
| ld_v_db | input | 1 | Load overflow from data bus bit 6 |
| ld_v_alu | input | 1 | Load overflow from ALU overflow output |
| set_v | input | 1 | Force overflow to 1 |
| clr_v | input | 1 | Force overflow to 0 |
| ld_n_db | input | 1 | Load negative from data bus bit 7 |
| drive_db | input | 1 | Place the packed status word on the data bus |
| flag_c | output | 1 | Carry |
| flag_z | output | 1 | Zero |
| flag_i | output | 1 | Interrupt-disable |
| flag_d | output | 1 | Decimal |
| flag_v | output | 1 | Overflow |
| flag_n | output | 1 | Negative |
| dbus_out | output | 8 | Packed status word, zero when not driving |
| dbus_oe | output | 1 | Data bus drive enable |

## Verification
The bench targets collisions, where two or three strobes for the same flag fire together with conflicting source values. A design with its priority reversed would then load the lower-ranked value. A large share of cycles present an all-zero data bus to the zero detector, so a detector that is inverted or misses a bit would produce the wrong zero flag. The bench also compares the packed word's fixed bits 5 and 4 and every flag position on every cycle, where a swapped field would show at once. A mid-run reset checks that interrupt-disable alone comes back as 1.

// File: rtl/status_flags_pkg.sv
package status_flags_pkg;

    // Bit positions in the packed status byte; other blocks decode these.
    localparam int POS_C = 0;
    localparam int POS_Z = 1;
    localparam int POS_I = 2;
    localparam int POS_D = 3;
    localparam int POS_K0 = 4;   // fixed 0
    localparam int POS_K1 = 5;   // fixed 1
    localparam int POS_V = 6;
    localparam int POS_N = 7;

    typedef struct packed {
        logic n;
        logic v;
        logic d;
        logic i;
        logic z;
        logic c;
    } flags_t;

endpackage

// File: rtl/status_flag_cell.sv
// One flag bit with a priority-ordered source selector; source 0 ranks highest.
module status_flag_cell #(
    parameter int   NSRC    = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] sel,
    input  logic [NSRC-1:0] src,
    output logic            q
);
    logic flag_d, flag_q;

    always_comb begin
        flag_d = flag_q;
        for (int s = NSRC - 1; s >= 0; s--) begin
            if (sel[s]) begin
                flag_d = src[s];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= RST_VAL;
        end else begin
            flag_q <= flag_d;
        end
    end

    assign q = flag_q;

    // R2: no strobe, no change
    assert_hold_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == '0) |=> $stable(q));

    // top-ranked source always wins when it is selected
    assert_top_source_wins_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sel[0] |=> (q == $past(src[0])));

endmodule

// File: rtl/status_zero_detect.sv
module status_zero_detect #(
    parameter int W = 8
) (
    input  logic [W-1:0] bus,
    output logic         is_zero
);
    assign is_zero = ~(|bus);
endmodule

// File: rtl/status_word_pack.sv
module status_word_pack
    import status_flags_pkg::*;
#(
    parameter int W = 8
) (
    input  flags_t       f,
    input  logic         oe,
    output logic [W-1:0] word
);
    logic [W-1:0] packed_d;

    always_comb begin
        packed_d          = '0;
        packed_d[POS_C]   = f.c;
        packed_d[POS_Z]   = f.z;
        packed_d[POS_I]   = f.i;
        packed_d[POS_D]   = f.d;
        packed_d[POS_K0]  = 1'b0;
        packed_d[POS_K1]  = 1'b1;
        packed_d[POS_V]   = f.v;
        packed_d[POS_N]   = f.n;
        word              = oe ? packed_d : '0;
    end
endmodule

// File: rtl/status_flags.sv
module status_flags
    import status_flags_pkg::*;
#(
    parameter int DB_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [DB_W-1:0] dbus_in,
    input  logic            ir_bit5,
    input  logic            alu_cout,
    input  logic            alu_vout,
    input  logic            ld_c_db,
    input  logic            ld_c_ir,
    input  logic            ld_c_alu,
    input  logic            ld_z_db,
    input  logic            ld_z_zero,
    input  logic            ld_i_db,
    input  logic            ld_i_ir,
    input  logic            ld_d_db,
    input  logic            ld_d_ir,
    input  logic            ld_v_db,
    input  logic            ld_v_alu,
    input  logic            set_v,
    input  logic            clr_v,
    input  logic            ld_n_db,
    input  logic            drive_db,
    output logic            flag_c,
    output logic            flag_z,
    output logic            flag_i,
    output logic            flag_d,
    output logic            flag_v,
    output logic            flag_n,
    output logic [DB_W-1:0] dbus_out,
    output logic            dbus_oe
);
    localparam int NSRC_C = 3;
    localparam int NSRC_V = 4;

    flags_t flags_q;
    logic   bus_zero;

    status_zero_detect #(.W(DB_W)) u_zdet (
        .bus     (dbus_in),
        .is_zero (bus_zero)
    );

    status_flag_cell #(.NSRC(NSRC_C), .RST_VAL(1'b0)) u_c (
        .clk (clk), .rst_n (rst_n),
        .sel ({ld_c_alu, ld_c_ir, ld_c_db}),
        .src ({alu_cout, ir_bit5, dbus_in[POS_C]}),
        .q   (flags_q.c)
    );

    status_flag_cell #(.NSRC(2), .RST_VAL(1'b0)) u_z (
        .clk (clk), .rst_n (rst_n),
        .sel ({ld_z_zero, ld_z_db}),
        .src ({bus_zero, dbus_in[POS_Z]}),
        .q   (flags_q.z)
    );

    status_flag_cell #(.NSRC(2), .RST_VAL(1'b1)) u_i (
        .clk (clk), .rst_n (rst_n),
        .sel ({ld_i_ir, ld_i_db}),
        .src ({ir_bit5, dbus_in[POS_I]}),
        .q   (flags_q.i)
    );

    status_flag_cell #(.NSRC(2), .RST_VAL(1'b0)) u_d (
        .clk (clk), .rst_n (rst_n),
        .sel ({ld_d_ir, ld_d_db}),
        .src ({ir_bit5, dbus_in[POS_D]}),
        .q   (flags_q.d)
    );

    status_flag_cell #(.NSRC(NSRC_V), .RST_VAL(1'b0)) u_v (
        .clk (clk), .rst_n (rst_n),
        .sel ({clr_v, set_v, ld_v_alu, ld_v_db}),
        .src ({1'b0, 1'b1, alu_vout, dbus_in[POS_V]}),
        .q   (flags_q.v)
    );

    status_flag_cell #(.NSRC(1), .RST_VAL(1'b0)) u_n (
        .clk (clk), .rst_n (rst_n),
        .sel (ld_n_db),
        .src (dbus_in[POS_N]),
        .q   (flags_q.n)
    );

    status_word_pack #(.W(DB_W)) u_pack (
        .f    (flags_q),
        .oe   (drive_db),
        .word (dbus_out)
    );

    assign dbus_oe = drive_db;
    assign flag_c  = flags_q.c;
    assign flag_z  = flags_q.z;
    assign flag_i  = flags_q.i;
    assign flag_d  = flags_q.d;
    assign flag_v  = flags_q.v;
    assign flag_n  = flags_q.n;

    assert_carry_ir_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_c_ir && !ld_c_db) |=> (flag_c == $past(ir_bit5)));
    assert_carry_alu_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_c_alu && !ld_c_ir && !ld_c_db) |=> (flag_c == $past(alu_cout)));
    assert_zero_detect_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_z_zero && !ld_z_db) |=> (flag_z == ($past(dbus_in) == '0)));
    assert_idis_ir_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_i_ir && !ld_i_db) |=> (flag_i == $past(ir_bit5)));
    assert_dec_ir_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_d_ir && !ld_d_db) |=> (flag_d == $past(ir_bit5)));
    assert_ovf_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (set_v && !ld_v_alu && !ld_v_db) |=> flag_v);
    assert_ovf_clr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_v && !set_v && !ld_v_alu && !ld_v_db) |=> !flag_v);
    assert_neg_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ld_n_db |=> (flag_n == $past(dbus_in[POS_N])));
    assert_word_fixed_R9: assert property (@(posedge clk) disable iff (!rst_n)
        drive_db |-> (dbus_out[POS_K1] && !dbus_out[POS_K0] && dbus_oe
                      && dbus_out[POS_C] == flag_c && dbus_out[POS_N] == flag_n));
    assert_word_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !drive_db |-> (dbus_out == '0 && !dbus_oe));

endmodule

// File: tb/status_flags_test.sv
`timescale 1ns/1ps
module status_flags_test;
    logic clk = 1'b0;
    logic rst_n = 1'b1;
    logic [7:0] dbus_in = '0;
    logic ir_bit5 = 0, alu_cout = 0, alu_vout = 0;
    logic ld_c_db = 0, ld_c_ir = 0, ld_c_alu = 0;
    logic ld_z_db = 0, ld_z_zero = 0;
    logic ld_i_db = 0, ld_i_ir = 0;
    logic ld_d_db = 0, ld_d_ir = 0;
    logic ld_v_db = 0, ld_v_alu = 0, set_v = 0, clr_v = 0;
    logic ld_n_db = 0, drive_db = 0;
    logic flag_c, flag_z, flag_i, flag_d, flag_v, flag_n, dbus_oe;
    logic [7:0] dbus_out;

    int checks = 0, fails = 0;
    logic mc, mz, mi, md, mv, mn;

    always #5 clk = ~clk;

    status_flags uut (.*);

    initial begin
        #1500000;
        fails++; checks++;
        $display("FAIL watchdog expired: actual hung, expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_all(input string rc, input string rz, input string ri,
                             input string rd, input string rv, input string rn);
        chk(rc, {7'd0, flag_c}, {7'd0, mc});
        chk(rz, {7'd0, flag_z}, {7'd0, mz});
        chk(ri, {7'd0, flag_i}, {7'd0, mi});
        chk(rd, {7'd0, flag_d}, {7'd0, md});
        chk(rv, {7'd0, flag_v}, {7'd0, mv});
        chk(rn, {7'd0, flag_n}, {7'd0, mn});
        chk("R9", {7'd0, dbus_oe}, {7'd0, drive_db});
        chk("R9", dbus_out, drive_db ? {mn, mv, 1'b1, 1'b0, md, mi, mz, mc} : 8'h00);
    endtask

    task automatic clear_strobes();
        {ld_c_db, ld_c_ir, ld_c_alu, ld_z_db, ld_z_zero, ld_i_db, ld_i_ir,
         ld_d_db, ld_d_ir, ld_v_db, ld_v_alu, set_v, clr_v, ld_n_db} = '0;
    endtask

    initial begin
        string tc, tz, ti, td, tv, tn;
        clear_strobes();
        @(negedge clk);
        rst_n = 1'b0;
        #3;
        mc = 0; mz = 0; mi = 1; md = 0; mv = 0; mn = 0;
        check_all("R1", "R1", "R1", "R1", "R1", "R1");
        @(negedge clk);
        drive_db = 1'b1;
        #1 check_all("R1", "R1", "R1", "R1", "R1", "R1");
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1", "R1", "R1", "R1", "R1", "R1");
        tc = "R2"; tz = "R2"; ti = "R2"; td = "R2"; tv = "R2"; tn = "R2";

        for (int k = 0; k < 20000; k++) begin
            if (k == 10000) begin
                clear_strobes();
                rst_n = 1'b0;
                #2;
                mc = 0; mz = 0; mi = 1; md = 0; mv = 0; mn = 0;
                check_all("R1", "R1", "R1", "R1", "R1", "R1");
                @(negedge clk);
                rst_n = 1'b1;
                tc = "R2"; tz = "R2"; ti = "R2"; td = "R2"; tv = "R2"; tn = "R2";
            end
            // apply new stimulus (inputs settle well before the next rising edge)
            dbus_in  = (k % 4 == 0) ? 8'h00 : 8'($urandom);
            ir_bit5  = 1'($urandom);
            alu_cout = 1'($urandom);
            alu_vout = 1'($urandom);
            ld_c_db  = ($urandom % 3) == 0;  ld_c_ir = ($urandom % 3) == 0;
            ld_c_alu = ($urandom % 3) == 0;
            ld_z_db  = ($urandom % 3) == 0;  ld_z_zero = ($urandom % 2) == 0;
            ld_i_db  = ($urandom % 3) == 0;  ld_i_ir = ($urandom % 3) == 0;
            ld_d_db  = ($urandom % 3) == 0;  ld_d_ir = ($urandom % 3) == 0;
            ld_v_db  = ($urandom % 4) == 0;  ld_v_alu = ($urandom % 4) == 0;
            set_v    = ($urandom % 3) == 0;  clr_v = ($urandom % 3) == 0;
            ld_n_db  = ($urandom % 2) == 0;
            drive_db = 1'($urandom);
            #1 chk("R9", dbus_out, drive_db ? {mn, mv, 1'b1, 1'b0, md, mi, mz, mc} : 8'h00);

            // expected next state from the requirements
            tc = "R2"; tz = "R2"; ti = "R2"; td = "R2"; tv = "R2"; tn = "R2";
            if (ld_c_db)       begin mc = dbus_in[0]; tc = "R3"; end
            else if (ld_c_ir)  begin mc = ir_bit5;    tc = "R3"; end
            else if (ld_c_alu) begin mc = alu_cout;   tc = "R3"; end
            if (ld_z_db)        begin mz = dbus_in[1];       tz = "R4"; end
            else if (ld_z_zero) begin mz = (dbus_in == 8'h00); tz = "R4"; end
            if (ld_i_db)       begin mi = dbus_in[2]; ti = "R5"; end
            else if (ld_i_ir)  begin mi = ir_bit5;    ti = "R5"; end
            if (ld_d_db)       begin md = dbus_in[3]; td = "R6"; end
            else if (ld_d_ir)  begin md = ir_bit5;    td = "R6"; end
            if (ld_v_db)       begin mv = dbus_in[6]; tv = "R7"; end
            else if (ld_v_alu) begin mv = alu_vout;   tv = "R7"; end
            else if (set_v)    begin mv = 1'b1;       tv = "R7"; end
            else if (clr_v)    begin mv = 1'b0;       tv = "R7"; end
            if (ld_n_db)       begin mn = dbus_in[7]; tn = "R8"; end

            @(negedge clk);
            check_all(tc, tz, ti, td, tv, tn);
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule